// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block is the control-transfer engine of a small 8-bit processor core. It owns the 16-bit program counter, the 8-bit stack pointer and the 8-bit status byte. It runs the multi-cycle bus sequences that move them to and from memory: the power-up vector fetch, hardware interrupt entry (maskable and non-maskable), software break, subroutine call and return, interrupt return, and the two status push/pull instructions. Instruction decode, arithmetic and operand addressing are handled elsewhere. The decoder hands this block one command at a time, together with a call target when needed.

Commands are raised by a start strobe together with a one-hot request vector. The block then reports busy, performs one memory access per cycle, and finally raises done for one cycle. The memory port is a single synchronous port: an address, write data and a write strobe go out, and read data returns in the cycle after the address was presented. Read captures are pipelined behind the next address, so a sequence of N accesses takes N+1 cycles before done.

Top module: `irq_stack_seq`

## Requirements
- R1: While rst_n is low, pc is 0x0000, sp is 0xFD, status is 0x36 and busy is high. After release the block reads 0xFFFC as the low PC byte and then 0xFFFD as the high byte, issues no write, and raises done exactly once with pc holding the vector.
- R2: The cmd_req bits are bit0 non-maskable interrupt, bit1 maskable interrupt, bit2 break, bit3 call, bit4 return, bit5 interrupt return, bit6 push status and bit7 pull status. A command is accepted on cmd_start only while idle and only with exactly one bit set. Any other request, or a start while busy, is ignored. Each accepted command produces exactly one single-cycle done pulse.
- R3: A push writes 0x0100+sp and then decrements sp, with 0x00 wrapping to 0xFF. A pop first increments sp, with 0xFF wrapping to 0x00, and then reads 0x0100+sp. Every write lands in page 0x01.
- R4: Hardware interrupt entry pushes PC[15:8], then PC[7:0], then status with bit 4 cleared. It then clears bit 4 and sets bit 2 (interrupt mask) in the status register, and loads pc little-endian from 0xFFFA/0xFFFB for the non-maskable request or from 0xFFFE/0xFFFF for the maskable one. The non-maskable request is taken whatever bit 2 holds.
- R5: A maskable interrupt request while status bit 2 is set causes no write and leaves pc, sp and status unchanged, but still completes with a done pulse.
- R6: Break pushes (PC+1)[15:8], then (PC+1)[7:0], then status with bit 4 forced to 1. It sets status bit 2, leaves bit 4 of the status register unchanged, and loads pc from 0xFFFE/0xFFFF.
- R7: Call pushes (PC-1)[15:8] and then (PC-1)[7:0], modulo 2^16, and loads pc with call_target as sampled on the accepting cycle.
- R8: Return pops a low byte and then a high byte, and loads pc with that value plus one, modulo 2^16.
- R9: Interrupt return pops status (bit 5 forced to 1), then the PC low byte, then the PC high byte, and loads pc with no adjustment.
- R10: Push status writes the status byte with bit 4 forced to 1 and leaves the status register unchanged.
- R11: Pull status loads status from the popped byte with bit 5 forced to 1. Status bit 5 reads 1 at all times.
- R12: The number of write strobes per command is 3 for either interrupt or break, 2 for call, 1 for push status, and 0 for return, interrupt return, pull status and a masked interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmd_start | input | 1 | Command strobe |
| cmd_req | input | 8 | One-hot command select |
| call_target | input | 16 | Destination for a call command |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status byte |

## Verification
The assertions assume that the memory returns read data exactly one cycle after the address and never stalls. They also assume that cmd_req and call_target stay stable only in the accepting cycle, and that nothing other than the block writes the stack page while a sequence runs. The bench memory is a registered array with that one-cycle latency. The bench changes inputs only on falling edges and preloads stack bytes only while the block is idle, so every assumed input behaviour holds throughout. The sweeps walk sp through both wrap points and drive call targets across the 16-bit boundary to exercise the wrap corners.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int AW   = 16;
  localparam int DW   = 8;
  localparam int NCMD = 8;

  localparam int SR_MASK_BIT = 2;
  localparam int SR_BRK_BIT  = 4;
  localparam int SR_ONE_BIT  = 5;

  localparam logic [DW-1:0] SR_AT_RESET = 8'h36;
  localparam logic [DW-1:0] SP_AT_RESET = 8'hFD;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_LO, ST_RST_HI, ST_PUSH_H, ST_PUSH_L, ST_PUSH_S,
    ST_VEC_LO, ST_VEC_HI, ST_POP_1, ST_POP_2, ST_POP_3, ST_FIN
  } seq_st_e;

  // Index of the one-hot request bit
  typedef enum logic [2:0] {
    OP_NMI = 3'd0, OP_IRQ = 3'd1, OP_BRK = 3'd2, OP_CALL = 3'd3,
    OP_RET = 3'd4, OP_RTI = 3'd5, OP_PSHS = 3'd6, OP_PULS = 3'd7
  } op_e;

  // Destination of the byte returning on the read bus next cycle
  typedef enum logic [2:0] {
    TG_NONE, TG_PCL, TG_PCH, TG_STAT, TG_TMPL, TG_PCH_INC
  } tag_e;
endpackage

// File: rtl/isq_sp_unit.sv
module isq_sp_unit
  import isq_pkg::*;
#(
  parameter int W = DW,
  parameter logic [W-1:0] RST_VAL = SP_AT_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  output logic [W-1:0] sp,
  output logic [W-1:0] sp_inc
);
  logic [W-1:0] sp_q, sp_d;
  logic         sp_en;

  assign sp_inc = sp_q + 1'b1;
  assign sp_en  = push | pop;

  always_comb begin
    sp_d = sp_q;
    if (push)     sp_d = sp_q - 1'b1;
    else if (pop) sp_d = sp_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RST_VAL;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == $past(sp_q) - 1'b1);
  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp_q == $past(sp_q) + 1'b1);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/isq_fsm.sv
module isq_fsm
  import isq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NCMD-1:0] req,
  input  logic            irq_masked,
  output seq_st_e         st,
  output op_e             op,
  output op_e             op_acc,
  output logic            accept,
  output tag_e            tag_issue,
  output logic            push,
  output logic            pop,
  output logic            busy,
  output logic            done
);
  seq_st_e st_q, st_d;
  op_e     op_q, op_d;
  logic    done_q, done_d;

  function automatic op_e op_of(input logic [NCMD-1:0] r);
    op_e o;
    o = OP_NMI;
    for (int i = 0; i < NCMD; i++)
      if (r[i]) o = op_e'(3'(i));
    return o;
  endfunction

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    accept    = 1'b0;
    tag_issue = TG_NONE;
    case (st_q)
      ST_IDLE: begin
        if (start && $onehot(req)) begin
          accept = 1'b1;
          op_d   = op_of(req);
          case (op_d)
            OP_NMI, OP_BRK, OP_CALL: st_d = ST_PUSH_H;
            OP_IRQ:                  st_d = irq_masked ? ST_FIN : ST_PUSH_H;
            OP_PSHS:                 st_d = ST_PUSH_S;
            default:                 st_d = ST_POP_1;
          endcase
        end
      end
      ST_RST_LO: begin tag_issue = TG_PCL; st_d = ST_RST_HI; end
      ST_RST_HI: begin tag_issue = TG_PCH; st_d = ST_FIN;    end
      ST_PUSH_H: st_d = ST_PUSH_L;
      ST_PUSH_L: st_d = (op_q == OP_CALL) ? ST_FIN : ST_PUSH_S;
      ST_PUSH_S: st_d = (op_q == OP_PSHS) ? ST_FIN : ST_VEC_LO;
      ST_VEC_LO: begin tag_issue = TG_PCL; st_d = ST_VEC_HI; end
      ST_VEC_HI: begin tag_issue = TG_PCH; st_d = ST_FIN;    end
      ST_POP_1: begin
        tag_issue = (op_q == OP_RET) ? TG_TMPL : TG_STAT;
        st_d      = (op_q == OP_PULS) ? ST_FIN : ST_POP_2;
      end
      ST_POP_2: begin
        tag_issue = (op_q == OP_RET) ? TG_PCH_INC : TG_PCL;
        st_d      = (op_q == OP_RET) ? ST_FIN : ST_POP_3;
      end
      ST_POP_3: begin tag_issue = TG_PCH; st_d = ST_FIN; end
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign done_d = (st_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RST_LO;
      op_q   <= OP_NMI;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (accept) op_q <= op_d;
    end
  end

  assign st     = st_q;
  assign op     = op_q;
  assign op_acc = op_d;
  assign push   = (st_q == ST_PUSH_H) || (st_q == ST_PUSH_L) || (st_q == ST_PUSH_S);
  assign pop    = (st_q == ST_POP_1) || (st_q == ST_POP_2) || (st_q == ST_POP_3);
  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_q != ST_FIN) |=> busy);
  p_reset_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RST_LO) |=> (st_q == ST_RST_HI));
endmodule

// File: rtl/isq_regs.sv
module isq_regs
  import isq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  seq_st_e       st,
  input  op_e           op,
  input  op_e           op_acc,
  input  logic          accept,
  input  tag_e          tag_issue,
  input  logic [DW-1:0] rdata,
  input  logic [AW-1:0] call_target,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] stat,
  output logic [AW-1:0] ret,
  output logic [DW-1:0] push_stat
);
  logic [AW-1:0] pc_q, pc_d, ret_q, ret_d, tgt_q, tgt_d;
  logic [DW-1:0] stat_q, stat_d, tmp_q, tmp_d;
  tag_e          tag_q;
  logic          hw_entry;

  localparam logic [DW-1:0] ONE_MASK = DW'(1) << SR_ONE_BIT;
  localparam logic [DW-1:0] BRK_MASK = DW'(1) << SR_BRK_BIT;

  assign hw_entry = (op == OP_NMI) || (op == OP_IRQ);

  always_comb begin
    pc_d   = pc_q;
    stat_d = stat_q;
    ret_d  = ret_q;
    tgt_d  = tgt_q;
    tmp_d  = tmp_q;
    if (accept) begin
      tgt_d = call_target;
      case (op_acc)
        OP_BRK:  ret_d = pc_q + 16'd1;
        OP_CALL: ret_d = pc_q - 16'd1;
        default: ret_d = pc_q;
      endcase
    end
    if (st == ST_PUSH_S && op != OP_PSHS) begin
      stat_d[SR_MASK_BIT] = 1'b1;
      if (hw_entry) stat_d[SR_BRK_BIT] = 1'b0;
    end
    if (st == ST_PUSH_L && op == OP_CALL) pc_d = tgt_q;
    case (tag_q)
      TG_PCL:     pc_d[7:0]  = rdata;
      TG_PCH:     pc_d[15:8] = rdata;
      TG_STAT:    stat_d     = rdata | ONE_MASK;
      TG_TMPL:    tmp_d      = rdata;
      TG_PCH_INC: pc_d       = {rdata, tmp_q} + 16'd1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      stat_q <= SR_AT_RESET;
      ret_q  <= '0;
      tgt_q  <= '0;
      tmp_q  <= '0;
      tag_q  <= TG_NONE;
    end else begin
      pc_q   <= pc_d;
      stat_q <= stat_d;
      tmp_q  <= tmp_d;
      tag_q  <= tag_issue;
      if (accept) begin
        ret_q <= ret_d;
        tgt_q <= tgt_d;
      end
    end
  end

  assign pc        = pc_q;
  assign stat      = stat_q;
  assign ret       = ret_q;
  assign push_stat = hw_entry ? (stat_q & ~BRK_MASK) : (stat_q | BRK_MASK);

  p_mask_on_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_VEC_LO) |-> stat_q[SR_MASK_BIT]);
  p_one_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[SR_ONE_BIT]);
  p_pushs_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PUSH_S && op == OP_PSHS) |=> $stable(stat_q));
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import isq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] RST_VEC    = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic [7:0]  cmd_req,
  input  logic [15:0] call_target,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  status
);
  seq_st_e       st;
  op_e           op, op_acc;
  tag_e          tag_issue;
  logic          accept, push, pop;
  logic [DW-1:0] sp_q, sp_inc, stat, push_stat;
  logic [AW-1:0] pc_q, ret;
  logic [AW-1:0] vec_base;

  isq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .req(cmd_req),
    .irq_masked(stat[SR_MASK_BIT]), .st(st), .op(op), .op_acc(op_acc),
    .accept(accept), .tag_issue(tag_issue), .push(push), .pop(pop),
    .busy(busy), .done(done)
  );

  isq_sp_unit u_sp (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .sp(sp_q), .sp_inc(sp_inc)
  );

  isq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .st(st), .op(op), .op_acc(op_acc),
    .accept(accept), .tag_issue(tag_issue), .rdata(mem_rdata),
    .call_target(call_target), .pc(pc_q), .stat(stat), .ret(ret),
    .push_stat(push_stat)
  );

  assign vec_base = (op == OP_NMI) ? NMI_VEC : IRQ_VEC;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_PUSH_H: begin mem_addr = {STACK_PAGE, sp_q}; mem_wdata = ret[15:8]; end
      ST_PUSH_L: begin mem_addr = {STACK_PAGE, sp_q}; mem_wdata = ret[7:0];  end
      ST_PUSH_S: begin mem_addr = {STACK_PAGE, sp_q}; mem_wdata = push_stat; end
      ST_POP_1, ST_POP_2, ST_POP_3: mem_addr = {STACK_PAGE, sp_inc};
      ST_RST_LO: mem_addr = RST_VEC;
      ST_RST_HI: mem_addr = RST_VEC + 16'd1;
      ST_VEC_LO: mem_addr = vec_base;
      ST_VEC_HI: mem_addr = vec_base + 16'd1;
      default:   ;
    endcase
  end

  assign mem_we = push;
  assign pc     = pc_q;
  assign sp     = sp_q;
  assign status = stat;

  p_we_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == STACK_PAGE));
  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || st == ST_FIN) |-> !mem_we);
  p_masked_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_req == 8'h02 && stat[SR_MASK_BIT]) |=> (!mem_we && $stable(sp_q)));
endmodule

// File: tb/irq_stack_seq_tb.sv
module irq_stack_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [7:0]  cmd_req = 8'h00;
  logic [15:0] call_target = 16'h0000;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, busy, done;
  logic [15:0] pc;
  logic [7:0]  sp, status;

  irq_stack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_req(cmd_req),
    .call_target(call_target), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done),
    .pc(pc), .sp(sp), .status(status)
  );

  always #5 clk = ~clk;

  // Memory model: stack page array plus computed vector bytes
  logic [7:0] stk_mem [256];
  logic [7:0] ref_stk [256];
  logic       pl_en = 1'b0;
  logic [7:0] pl_a = 8'h00, pl_d = 8'h00;

  function automatic logic [7:0] vec_byte(input logic [2:0] i);
    case (i)
      3'd2: return 8'h11;
      3'd3: return 8'h90;
      3'd4: return 8'h34;
      3'd5: return 8'h12;
      3'd6: return 8'h78;
      3'd7: return 8'hA5;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (pl_en) stk_mem[pl_a] <= pl_d;
    else if (mem_we && mem_addr[15:8] == 8'h01) stk_mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_addr[15:8] == 8'h01)           mem_rdata <= stk_mem[mem_addr[7:0]];
    else if (mem_addr[15:3] == 13'h1FFF)   mem_rdata <= vec_byte(mem_addr[2:0]);
    else                                   mem_rdata <= 8'h00;
  end

  int wr_cnt = 0, done_cnt = 0;
  always @(posedge clk) begin
    if (rst_n && mem_we) wr_cnt <= wr_cnt + 1;
    if (rst_n && done)   done_cnt <= done_cnt + 1;
  end

  int nvec = 0, nfail = 0;
  logic [15:0] m_pc;
  logic [7:0]  m_sp, m_st;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); pl_en = 1'b1; pl_a = a; pl_d = d;
    @(negedge clk); pl_en = 1'b0;
    ref_stk[a] = d;
  endtask

  task automatic m_push(input logic [7:0] b);
    ref_stk[m_sp] = b; m_sp = m_sp - 8'd1;
  endtask

  function automatic logic [7:0] m_pop();
    m_sp = m_sp + 8'd1;
    return ref_stk[m_sp];
  endfunction

  task automatic run(input logic [7:0] req, input logic [15:0] tgt, input bit poke, input string rq);
    int d0, w0, expw, k;
    logic [15:0] r;
    logic [7:0] lo, hi;
    expw = 0;
    case (req)
      8'h01, 8'h02: begin
        if (req == 8'h02 && m_st[2]) expw = 0;
        else begin
          m_push(m_pc[15:8]); m_push(m_pc[7:0]); m_push(m_st & 8'hEF);
          m_st = (m_st & 8'hEF) | 8'h04;
          m_pc = (req == 8'h01) ? {vec_byte(3), vec_byte(2)} : {vec_byte(7), vec_byte(6)};
          expw = 3;
        end
      end
      8'h04: begin
        r = m_pc + 16'd1;
        m_push(r[15:8]); m_push(r[7:0]); m_push(m_st | 8'h10);
        m_st = m_st | 8'h04; m_pc = {vec_byte(7), vec_byte(6)}; expw = 3;
      end
      8'h08: begin
        r = m_pc - 16'd1;
        m_push(r[15:8]); m_push(r[7:0]); m_pc = tgt; expw = 2;
      end
      8'h10: begin lo = m_pop(); hi = m_pop(); m_pc = {hi, lo} + 16'd1; end
      8'h20: begin m_st = m_pop() | 8'h20; lo = m_pop(); hi = m_pop(); m_pc = {hi, lo}; end
      8'h40: begin m_push(m_st | 8'h10); expw = 1; end
      default: begin m_st = m_pop() | 8'h20; end
    endcase
    d0 = done_cnt; w0 = wr_cnt;
    @(negedge clk); cmd_start = 1'b1; cmd_req = req; call_target = tgt;
    @(negedge clk); cmd_start = 1'b0; call_target = ~tgt;
    if (poke) begin
      cmd_start = 1'b1; cmd_req = 8'h40;
      @(negedge clk); cmd_start = 1'b0;
    end
    cmd_req = 8'h00;
    k = 0;
    while (done_cnt == d0 && k < 40) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    chk("R2", "done pulses", done_cnt - d0, 1);
    chk(rq, "R12 write strobes", wr_cnt - w0, expw);
    chk(rq, "pc", pc, m_pc);
    chk(rq, "sp", sp, m_sp);
    chk(rq, "status", status, m_st);
  endtask

  function automatic int stack_diff();
    int n = 0;
    for (int i = 0; i < 256; i++) if (stk_mem[i] !== ref_stk[i]) n++;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int d0, w0, k;
    logic [15:0] t;
    for (int i = 0; i < 256; i++) ref_stk[i] = 8'h00;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", pc, 16'h0000);
    chk("R1", "sp in reset", sp, 8'hFD);
    chk("R1", "status in reset", status, 8'h36);
    chk("R1", "busy in reset", busy, 1'b1);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); pl_en = 1'b1; pl_a = 8'(i); pl_d = 8'h00;
    end
    @(negedge clk); pl_en = 1'b0;
    d0 = done_cnt; w0 = wr_cnt;
    rst_n = 1'b1;
    k = 0;
    while (done_cnt == d0 && k < 40) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    chk("R1", "vector pc", pc, 16'h1234);
    chk("R1", "done pulses", done_cnt - d0, 1);
    chk("R1", "writes", wr_cnt - w0, 0);
    m_pc = 16'h1234; m_sp = 8'hFD; m_st = 8'h36;

    // R2 malformed requests are ignored
    foreach (cmd_req[b]) begin end
    d0 = done_cnt;
    @(negedge clk); cmd_start = 1'b1; cmd_req = 8'h03;
    @(negedge clk); cmd_start = 1'b0; cmd_req = 8'h00;
    chk("R2", "busy after two-hot", busy, 1'b0);
    @(negedge clk); cmd_start = 1'b1; cmd_req = 8'h00;
    @(negedge clk); cmd_start = 1'b0;
    chk("R2", "busy after empty", busy, 1'b0);
    repeat (4) @(negedge clk);
    chk("R2", "no done", done_cnt - d0, 0);

    // Nested entry and exit
    run(8'h02, 16'h0, 1'b0, "R5");
    run(8'h01, 16'h0, 1'b0, "R4");
    run(8'h04, 16'h0, 1'b0, "R6");
    run(8'h02, 16'h0, 1'b0, "R5");
    run(8'h40, 16'h0, 1'b1, "R10");
    run(8'h80, 16'h0, 1'b0, "R11");
    chk("R3", "stack image", stack_diff(), 0);
    run(8'h20, 16'h0, 1'b0, "R9");
    run(8'h20, 16'h0, 1'b0, "R9");
    // Unmask, then maskable entry is taken
    preload(m_sp + 8'd1, 8'h00);
    run(8'h80, 16'h0, 1'b0, "R11");
    run(8'h02, 16'h0, 1'b0, "R4");
    run(8'h01, 16'h0, 1'b0, "R4");
    chk("R3", "stack image", stack_diff(), 0);
    run(8'h20, 16'h0, 1'b0, "R9");
    run(8'h20, 16'h0, 1'b0, "R9");

    // R7/R8 call and return sweep including 16-bit wrap
    for (int i = 0; i < 40; i++) begin
      case (i)
        0: t = 16'h0000;
        1: t = 16'hFFFF;
        2: t = 16'h00FF;
        3: t = 16'h0100;
        default: t = 16'(i * 16'h0683) ^ 16'h5A00;
      endcase
      run(8'h08, t, 1'b0, "R7");
      run(8'h08, ~t, 1'b0, "R7");
      run(8'h10, 16'h0, 1'b0, "R8");
      run(8'h10, 16'h0, 1'b0, "R8");
    end
    chk("R3", "stack image", stack_diff(), 0);

    // R3 pointer wrap sweep
    for (int i = 0; i < 260; i++) run(8'h40, 16'h0, 1'b0, "R3");
    chk("R3", "stack image", stack_diff(), 0);
    for (int i = 0; i < 256; i++) preload(8'(i), 8'(i * 37 + 5));
    for (int i = 0; i < 260; i++) run(8'h80, 16'h0, 1'b0, "R3");
    chk("R3", "stack image", stack_diff(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule